// File: doc/BRIEF.md
# Board-Variant Display Control and Card Status Registers

This block holds two memory-mapped registers whose behaviour is selected by a board-type number presented on an input. The display control word has a read-only status field, a set of writable bits and a reset value, all of which depend on the board type. On one board type, writes to it also drive a 2-bit format-select output to an external display multiplexer. The card status word reports two level inputs, card-present and write-protect. The bit position of the write-protect flag depends on the board type.

A small control state machine has two states. `ST_LOAD` is entered on reset. `ST_RUN` is the operating state. The transitions are:
- reset to `ST_LOAD`;
- `ST_LOAD` to `ST_RUN`, unconditionally after one cycle;
- `ST_RUN` to `ST_RUN`.

In `ST_LOAD` the block captures the board type and loads the display word with its board-dependent reset value. From then on it serves the register port. Register accesses are single-cycle: a write is taken on the rising clock edge, and read data is combinational from the address.

Top module: `bvd_regs`

## Requirements
- R1: After reset, the display word (offset 0x50) reads 0x00001F00 for every board type except 0x190, where it reads 0x00000000.
- R2: On board types 0x100 and 0x140, a write to the display word keeps bits 13:8 unchanged and takes every other bit from the write data.
- R3: The format-select output resets to 0. On board type 0x100 it takes bits 1:0 of each write to the display word. At all other times, and on every other board type, it holds its value.
- R4: On board type 0x140, a write to the display word uses the masking of R2 and leaves the format-select output unchanged.
- R5: On board types 0x178 and 0x182, a write to the display word changes only bit 7; all other bits keep their value.
- R6: On board type 0x190, the display word always reads zero and writes are ignored. On board types not named in R2 to R6, writes are ignored and the word keeps the value 0x00001F00.
- R7: The card status word (offset 0x48) is laid out as follows:
  - bit 0 is the card-present level;
  - the write-protect level is at bit 2 on board types 0x100 and 0x140, and at bit 1 on all other board types;
  - all other bits read zero;
  - writes to the word are ignored.
- R8: Each card input passes through a two-flop synchroniser. A level change applied before a rising edge is not visible after that edge, and is visible after the following edge.
- R9: For exactly one cycle after reset is released (`ST_LOAD`), all reads return zero and writes are ignored. The block then stays in `ST_RUN`.
- R10: The board type is captured in `ST_LOAD`. Later changes on the board-type input have no effect until the next reset.
- R11: Reads of any other offset return zero. Writes to any other offset change neither register nor the format-select output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| board_id_i | input | 12 | Board-type number, captured after reset |
| wr_en_i | input | 1 | Write strobe, taken on the rising edge |
| addr_i | input | 8 | Byte offset of the access |
| wdata_i | input | 32 | Write data |
| rd_data_o | output | 32 | Read data for addr_i (combinational) |
| card_present_i | input | 1 | Card-present level (asynchronous) |
| wprot_i | input | 1 | Write-protect level (asynchronous) |
| fmt_sel_o | output | 2 | Format select to the display multiplexer |

## Verification
A wrong write mask or a wrongly captured board type becomes visible on `rd_data_o` at the first read of the display word after a single write of all ones. It is also visible in the cycle after `ST_LOAD`, because the reset value differs between board types. A wrong format-select register shows on `fmt_sel_o` in the cycle after any write, including writes to other offsets and writes on other board types. A synchroniser with the wrong depth or a misplaced write-protect bit shows on the card status read one edge early or late, or at the wrong bit position, within two cycles of an input change.

// File: rtl/bvd_pkg.sv
package bvd_pkg;

    // Board variant classes selected from the captured board number
    typedef enum logic [2:0] {
        BV_MUXED,   // masked display word plus format-select output
        BV_NOMUX,   // masked display word, no format select
        BV_BIT7,    // only bit 7 of display word writable
        BV_BLANK,   // display word reads zero, writes ignored
        BV_OTHER    // unlisted board: writes ignored
    } board_class_e;

    typedef enum logic {
        ST_LOAD,
        ST_RUN
    } ctl_state_e;

endpackage

// File: rtl/bvd_board_decode.sv
module bvd_board_decode
    import bvd_pkg::*;
#(
    parameter int                 BOARD_W   = 12,
    parameter logic [BOARD_W-1:0] ID_MUXED  = 12'h100,
    parameter logic [BOARD_W-1:0] ID_NOMUX  = 12'h140,
    parameter logic [BOARD_W-1:0] ID_BIT7_A = 12'h178,
    parameter logic [BOARD_W-1:0] ID_BIT7_B = 12'h182,
    parameter logic [BOARD_W-1:0] ID_BLANK  = 12'h190
) (
    input  logic [BOARD_W-1:0] board_i,
    output board_class_e       class_o
);

    always_comb begin
        if (board_i == ID_MUXED) begin
            class_o = BV_MUXED;
        end else if (board_i == ID_NOMUX) begin
            class_o = BV_NOMUX;
        end else if ((board_i == ID_BIT7_A) || (board_i == ID_BIT7_B)) begin
            class_o = BV_BIT7;
        end else if (board_i == ID_BLANK) begin
            class_o = BV_BLANK;
        end else begin
            class_o = BV_OTHER;
        end
    end

endmodule

// File: rtl/bvd_sync.sv
module bvd_sync #(
    parameter int STAGES = 2,
    parameter int W      = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);

    logic [STAGES-1:0][W-1:0] pipe;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pipe <= '0;
        end else begin
            pipe[0] <= d_i;
            for (int s = 1; s < STAGES; s++) begin
                pipe[s] <= pipe[s-1];
            end
        end
    end

    assign q_o = pipe[STAGES-1];

endmodule

// File: rtl/bvd_disp_reg.sv
module bvd_disp_reg
    import bvd_pkg::*;
#(
    parameter int                DATA_W    = 32,
    parameter int                RO_LSB    = 8,
    parameter int                RO_MSB    = 13,
    parameter int                WR_BIT    = 7,
    parameter logic [DATA_W-1:0] RESET_VAL = 32'h0000_1F00
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic              wr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  board_class_e      class_i,
    output logic [DATA_W-1:0] q_o
);

    localparam int                RO_LEN   = RO_MSB - RO_LSB + 1;
    localparam logic [DATA_W-1:0] RO_FIELD = ((DATA_W'(1) << RO_LEN) - DATA_W'(1)) << RO_LSB;
    localparam logic [DATA_W-1:0] WR_ONLY  = DATA_W'(1) << WR_BIT;

    logic [DATA_W-1:0] keep_mask;
    logic [DATA_W-1:0] merged;
    logic [DATA_W-1:0] load_val;

    always_comb begin
        unique case (class_i)
            BV_MUXED, BV_NOMUX: keep_mask = RO_FIELD;
            BV_BIT7:            keep_mask = ~WR_ONLY;
            default:            keep_mask = '1;
        endcase
    end

    assign merged   = (q_o & keep_mask) | (wdata_i & ~keep_mask);
    assign load_val = (class_i == BV_BLANK) ? '0 : RESET_VAL;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_o <= '0;
        end else if (load_i) begin
            q_o <= load_val;
        end else if (wr_i) begin
            q_o <= merged;
        end
    end

    // R2
    ro_field_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && wr_i && ((class_i == BV_MUXED) || (class_i == BV_NOMUX)))
        |=> ((q_o & RO_FIELD) == ($past(q_o) & RO_FIELD)));

    // R5
    bit7_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && wr_i && (class_i == BV_BIT7))
        |=> ((q_o & ~WR_ONLY) == ($past(q_o) & ~WR_ONLY)));

    // R6
    blank_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && (class_i == BV_BLANK)) |-> (q_o == '0));

endmodule

// File: rtl/bvd_regs.sv
module bvd_regs
    import bvd_pkg::*;
#(
    parameter int                 DATA_W      = 32,
    parameter int                 ADDR_W      = 8,
    parameter int                 BOARD_W     = 12,
    parameter int                 SYNC_STAGES = 2,
    parameter logic [ADDR_W-1:0]  DISP_OFS    = 8'h50,
    parameter logic [ADDR_W-1:0]  CARD_OFS    = 8'h48,
    parameter int                 CP_BIT      = 0,
    parameter int                 WP_BIT_EARLY = 2,
    parameter int                 WP_BIT_LATE = 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [BOARD_W-1:0] board_id_i,
    input  logic               wr_en_i,
    input  logic [ADDR_W-1:0]  addr_i,
    input  logic [DATA_W-1:0]  wdata_i,
    output logic [DATA_W-1:0]  rd_data_o,
    input  logic               card_present_i,
    input  logic               wprot_i,
    output logic [1:0]         fmt_sel_o
);

    ctl_state_e         state, state_nx;
    logic               load_now;
    logic               run_now;
    logic [BOARD_W-1:0] board_q;
    logic [BOARD_W-1:0] board_eff;
    board_class_e       cls;
    logic               disp_wr;
    logic [DATA_W-1:0]  disp_q;
    logic [1:0]         card_sync;
    logic [DATA_W-1:0]  card_word;

    // ---------------- control state machine ----------------
    always_comb begin
        unique case (state)
            ST_LOAD: state_nx = ST_RUN;
            ST_RUN:  state_nx = ST_RUN;
            default: state_nx = ST_LOAD;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_LOAD;
        end else begin
            state <= state_nx;
        end
    end

    always_comb begin
        load_now = 1'b0;
        run_now  = 1'b0;
        unique case (state)
            ST_LOAD: load_now = 1'b1;
            ST_RUN:  run_now  = 1'b1;
            default: load_now = 1'b0;
        endcase
    end

    // ---------------- board capture and decode ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            board_q <= '0;
        end else if (load_now) begin
            board_q <= board_id_i;
        end
    end

    assign board_eff = load_now ? board_id_i : board_q;

    bvd_board_decode #(
        .BOARD_W (BOARD_W)
    ) u_decode (
        .board_i (board_eff),
        .class_o (cls)
    );

    // ---------------- display word ----------------
    assign disp_wr = run_now && wr_en_i && (addr_i == DISP_OFS);

    bvd_disp_reg #(
        .DATA_W (DATA_W)
    ) u_disp (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (load_now),
        .wr_i    (disp_wr),
        .wdata_i (wdata_i),
        .class_i (cls),
        .q_o     (disp_q)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fmt_sel_o <= 2'b00;
        end else if (disp_wr && (cls == BV_MUXED)) begin
            fmt_sel_o <= wdata_i[1:0];
        end
    end

    // ---------------- card status word ----------------
    bvd_sync #(
        .STAGES (SYNC_STAGES),
        .W      (2)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   ({wprot_i, card_present_i}),
        .q_o   (card_sync)
    );

    always_comb begin
        card_word         = '0;
        card_word[CP_BIT] = card_sync[0];
        if ((cls == BV_MUXED) || (cls == BV_NOMUX)) begin
            card_word[WP_BIT_EARLY] = card_sync[1];
        end else begin
            card_word[WP_BIT_LATE] = card_sync[1];
        end
    end

    // ---------------- read mux ----------------
    always_comb begin
        rd_data_o = '0;
        if (run_now) begin
            if (addr_i == DISP_OFS) begin
                rd_data_o = disp_q;
            end else if (addr_i == CARD_OFS) begin
                rd_data_o = card_word;
            end
        end
    end

    // R9
    load_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_LOAD) |=> (state == ST_RUN));

    // R3
    fmt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(disp_wr && (cls == BV_MUXED)) |=> $stable(fmt_sel_o));

    // R10
    board_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN) |=> $stable(board_q));

    // R7
    card_wp_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((cls == BV_MUXED) || (cls == BV_NOMUX)) |-> (card_word[WP_BIT_LATE] == 1'b0));

    // R11
    unmapped_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((addr_i != DISP_OFS) && (addr_i != CARD_OFS)) |-> (rd_data_o == '0));

endmodule

// File: tb/bvd_regs_test.sv
`timescale 1ns/1ps
module bvd_regs_test;

    localparam logic [7:0] DISP = 8'h50;
    localparam logic [7:0] CARD = 8'h48;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] board = 12'h100;
    logic        wr_en = 1'b0;
    logic [7:0]  addr = 8'h00;
    logic [31:0] wdata = '0;
    logic [31:0] rd_data;
    logic        cp = 1'b0;
    logic        wp = 1'b0;
    logic [1:0]  fmt_sel;

    int total = 0;
    int bad   = 0;

    always #4 clk = ~clk;

    bvd_regs uut (
        .clk            (clk),
        .rst_n          (rst_n),
        .board_id_i     (board),
        .wr_en_i        (wr_en),
        .addr_i         (addr),
        .wdata_i        (wdata),
        .rd_data_o      (rd_data),
        .card_present_i (cp),
        .wprot_i        (wp),
        .fmt_sel_o      (fmt_sel)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Leaves the design in its load cycle, just after a falling edge
    task automatic do_reset(logic [11:0] b);
        @(negedge clk);
        rst_n = 1'b0;
        wr_en = 1'b0;
        board = b;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic rd(logic [7:0] a, output logic [31:0] v);
        addr = a;
        #1;
        v = rd_data;
    endtask

    task automatic wr(logic [7:0] a, logic [31:0] d);
        addr  = a;
        wdata = d;
        wr_en = 1'b1;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic t_reset_load();
        logic [31:0] v;
        do_reset(12'h100);
        rd(DISP, v);
        check("R9 read in load cycle", v, 32'h0);
        wr(DISP, 32'hFFFF_FFFF);   // issued in load cycle: ignored
        rd(DISP, v);
        check("R9 write in load ignored / R1 reset 0x100", v, 32'h0000_1F00);
        check("R3 fmt reset", {30'd0, fmt_sel}, 32'h0);
        do_reset(12'h190);
        step();
        rd(DISP, v);
        check("R1 reset 0x190", v, 32'h0);
    endtask

    task automatic t_board_muxed();
        logic [31:0] v;
        do_reset(12'h100);
        step();
        wr(DISP, 32'hFFFF_FFFF);
        rd(DISP, v);
        check("R2 ones write 0x100", v, 32'hFFFF_DFFF);
        check("R3 fmt follows write", {30'd0, fmt_sel}, 32'h3);
        wr(DISP, 32'h0000_0002);
        rd(DISP, v);
        check("R2 low write 0x100", v, 32'h0000_1F02);
        check("R3 fmt second write", {30'd0, fmt_sel}, 32'h2);
        wr(CARD, 32'h0000_0001);
        check("R3 fmt holds on other write", {30'd0, fmt_sel}, 32'h2);
    endtask

    task automatic t_board_nomux();
        logic [31:0] v;
        do_reset(12'h140);
        step();
        wr(DISP, 32'hFFFF_FFFF);
        rd(DISP, v);
        check("R4 masking 0x140", v, 32'hFFFF_DFFF);
        check("R4 fmt unchanged", {30'd0, fmt_sel}, 32'h0);
    endtask

    task automatic t_board_bit7();
        logic [31:0] v;
        do_reset(12'h178);
        step();
        wr(DISP, 32'hFFFF_FFFF);
        rd(DISP, v);
        check("R5 ones write 0x178", v, 32'h0000_1F80);
        wr(DISP, 32'h0000_0000);
        rd(DISP, v);
        check("R5 zero write 0x178", v, 32'h0000_1F00);
        do_reset(12'h182);
        step();
        wr(DISP, 32'h0000_0080);
        rd(DISP, v);
        check("R5 bit7 write 0x182", v, 32'h0000_1F80);
        check("R3 fmt unchanged 0x182", {30'd0, fmt_sel}, 32'h0);
    endtask

    task automatic t_board_blank_other();
        logic [31:0] v;
        do_reset(12'h190);
        step();
        wr(DISP, 32'hFFFF_FFFF);
        rd(DISP, v);
        check("R6 write ignored 0x190", v, 32'h0);
        do_reset(12'h123);
        step();
        rd(DISP, v);
        check("R1 reset other board", v, 32'h0000_1F00);
        wr(DISP, 32'h0000_00FF);
        rd(DISP, v);
        check("R6 write ignored other board", v, 32'h0000_1F00);
    endtask

    task automatic t_card();
        logic [31:0] v;
        cp = 1'b0;
        wp = 1'b0;
        do_reset(12'h100);
        step();
        step();
        rd(CARD, v);
        check("R7 card idle", v, 32'h0);
        cp = 1'b1;
        wp = 1'b1;
        step();
        rd(CARD, v);
        check("R8 not visible after one edge", v, 32'h0);
        step();
        rd(CARD, v);
        check("R7 R8 both set on 0x100", v, 32'h5);
        wr(CARD, 32'h0000_0000);
        rd(CARD, v);
        check("R7 card write ignored", v, 32'h5);
        cp = 1'b0;
        step();
        step();
        rd(CARD, v);
        check("R7 card-present cleared", v, 32'h4);
        cp = 1'b1;
        do_reset(12'h182);
        step();
        step();
        step();
        rd(CARD, v);
        check("R7 wp at bit 1 on 0x182", v, 32'h3);
        cp = 1'b0;
        wp = 1'b0;
    endtask

    task automatic t_latch();
        logic [31:0] v;
        do_reset(12'h190);
        step();
        board = 12'h100;
        step();
        wr(DISP, 32'hFFFF_FFFF);
        rd(DISP, v);
        check("R10 board change ignored", v, 32'h0);
        check("R10 fmt unaffected", {30'd0, fmt_sel}, 32'h0);
    endtask

    task automatic t_unmapped();
        logic [31:0] v;
        do_reset(12'h100);
        step();
        wr(8'h4C, 32'hFFFF_FFFF);
        rd(DISP, v);
        check("R11 disp untouched", v, 32'h0000_1F00);
        check("R11 fmt untouched", {30'd0, fmt_sel}, 32'h0);
        rd(8'h4C, v);
        check("R11 unmapped read", v, 32'h0);
    endtask

    initial begin
        t_reset_load();
        t_board_muxed();
        t_board_nomux();
        t_board_bit7();
        t_board_blank_other();
        t_card();
        t_latch();
        t_unmapped();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #800000;
        total++;
        bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule